// File: doc/BRIEF.md
# SSI Slave Transmitter

This block answers a synchronous serial interface (SSI) master with a 24-bit word. The master supplies only a clock, `ssi_clk`, which idles high. The block drives one data line, `ssi_dout`. A host writes the word to send through a small valid/ready port. The block holds that word until the master starts the next frame. The first falling clock edge of a frame copies the held word into the shifter. Each rising edge after that presents the next bit, most significant bit first.

The master then sends one extra clock pulse to close the frame. The block does not shift on that pulse: the data line simply goes high. A monoflop counter, clocked by the system clock, restarts on every master clock edge. When no edge has arrived for `TIMEOUT_CYC` system cycles, the frame is over. The same timeout recovers a frame that the master abandoned midway, so every new frame starts from the most significant bit and frames never drift by one bit.

The master clock passes through a two-flop synchroniser before edge detection. For that reason each master clock phase must last at least three system clock cycles. Back-pressure rule: `ld_ready` is high at all times once reset is released, so the host never stalls. A word is accepted on any cycle where `ld_valid` and `ld_ready` are both high. A later accepted word replaces an earlier one that no frame has yet used.

Top module: `ssi_slave_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ssi_dout` is 1 and `busy` is 0. From the first cycle after release, `ld_ready` is 1.
- R2: A word on `ld_data` is accepted on every cycle where `ld_valid` and `ld_ready` are both high. The most recently accepted word is the one the next frame sends.
- R3: When no frame is active, a falling edge on `ssi_clk` starts a frame. It captures the held word and sets `busy` to 1.
- R4: During a frame, the k-th rising edge (k = 1..24) drives bit 24-k of the captured word (bit 23 first) onto `ssi_dout`. The line changes only on rising edges until the frame ends.
- R5: The rising edge that follows the 24th data bit (the end-of-frame pulse) drives `ssi_dout` to 1 and shifts nothing. The line stays 1 until the timeout ends the frame.
- R6: `busy` stays 1 while master clock edges keep arriving. It falls once `TIMEOUT_CYC` system cycles pass with no edge.
- R7: If the master stops clocking mid-frame, the timeout ends the frame. The next frame sends a newly loaded word starting from bit 23.
- R8: A word accepted while a frame is in progress does not change the bits of that frame. It is sent by the following frame.
- R9: Back-to-back frames of the same word return that word unchanged every time, with no cumulative one-bit shift.
- R10: Whenever `busy` is 0, `ssi_dout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ssi_clk | input | 1 | Master clock, asynchronous, idles high |
| ssi_dout | output | 1 | Serial data to the master |
| ld_valid | input | 1 | Host word valid |
| ld_ready | output | 1 | Host port ready (high whenever out of reset) |
| ld_data | input | 24 | Host word |
| busy | output | 1 | A frame is in progress (monoflop active) |

## Verification
On every cycle, the assertions check four things. The data line is high while idle. A frame starting edge raises `busy`, and `busy` survives every master edge. The bit counter never passes the word length and is back to zero when the frame ends. The data line moves only on a synchronised rising edge or at the timeout. Only the bench's scenarios can show end-to-end correctness. That covers the serial word matching the loaded word bit for bit, and the absence of drift across repeated frames. It also covers recovery from an abandoned frame, and isolation of a frame from a host write made during it.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int DEF_DATA_W  = 24;
  localparam int DEF_TIMEOUT = 5000; // 20 us at 250 MHz
  localparam int DEF_SYNC    = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } ssi_edge_t;
endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync
  import ssi_pkg::*;
#(
  parameter int STAGES = DEF_SYNC
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  output ssi_edge_t edges
);
  // chain: [0..STAGES-1] synchroniser, [STAGES] previous sample
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign edges.rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign edges.fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic active,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign expire = act_q && !kick && (cnt_q == LIMIT);
  assign active = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (kick) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              expire,
  input  logic [DATA_W-1:0] word,
  output logic              sdo,
  output logic [CNT_W-1:0]  bitcnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bitcnt <= '0;
      sdo    <= 1'b1;
    end else if (expire) begin
      bitcnt <= '0;
      sdo    <= 1'b1;
    end else if (start) begin
      sh_q   <= word;
      bitcnt <= '0;
      sdo    <= 1'b1;
    end else if (step) begin
      if (bitcnt < LAST) begin
        sdo    <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end else begin
        sdo    <= 1'b1; // end-of-frame pulse: no shift
      end
    end
  end
endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx
  import ssi_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int TIMEOUT_CYC = DEF_TIMEOUT,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ssi_clk,
  output logic              ssi_dout,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W-1:0] ld_data,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  ssi_edge_t         edges;
  logic              edge_any;
  logic              mf_active;
  logic              mf_expire;
  logic [DATA_W-1:0] pend_q;
  logic              rdy_q;
  logic [CNT_W-1:0]  bitcnt;

  ssi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ssi_clk), .edges(edges)
  );

  assign edge_any = edges.rise | edges.fall;

  ssi_monoflop #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mono (
    .clk(clk), .rst_n(rst_n), .kick(edge_any),
    .active(mf_active), .expire(mf_expire)
  );

  // host holding register, never back-pressures
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (ld_valid && rdy_q) pend_q <= ld_data;
    end
  end

  ssi_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(edges.fall && !mf_active),
    .step(edges.rise && mf_active),
    .expire(mf_expire),
    .word(pend_q),
    .sdo(ssi_dout),
    .bitcnt(bitcnt)
  );

  assign ld_ready = rdy_q;
  assign busy     = mf_active;
endmodule

// File: rtl/ssi_slave_tx_chk.sv
module ssi_slave_tx_chk #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sdo,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [DATA_W-1:0] ld_data,
  input logic [DATA_W-1:0] pend,
  input logic              rise,
  input logic              fall,
  input logic              expire,
  input logic [CNT_W-1:0]  bitcnt
);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !busy) |=> busy);

  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> busy);

  // R4
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(DATA_W));

  // R4
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise && !fall && !expire) |=> $stable(sdo));

  // R7
  end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bitcnt == '0));

  // R2
  host_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (pend == $past(ld_data)));
endmodule

bind ssi_slave_tx ssi_slave_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sdo(ssi_dout),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
  .pend(pend_q), .rise(edges.rise), .fall(edges.fall),
  .expire(mf_expire), .bitcnt(bitcnt)
);

// File: tb/sim_ssi_slave_tx.sv
`timescale 1ns/1ps
module sim_ssi_slave_tx;
  localparam int W    = 24;
  localparam int TOUT = 64;
  localparam int HALF = 10;
  localparam int NV   = 6;
  localparam logic [W-1:0] VEC [NV] = '{
    24'hA5C33C, 24'h010101, 24'h010101, 24'h010101, 24'hFFFFFF, 24'h800001
  };

  logic clk = 0, rst_n = 0, ssi_clk = 1, ld_valid = 0;
  logic [W-1:0] ld_data = '0;
  logic ssi_dout, ld_ready, busy;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ssi_slave_tx #(.DATA_W(W), .TIMEOUT_CYC(TOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .ssi_clk(ssi_clk), .ssi_dout(ssi_dout),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] w);
    @(posedge clk); #1 ld_valid = 1; ld_data = w;
    @(posedge clk); #1 ld_valid = 0;
  endtask

  task automatic frame(input int nrise, output logic [W-1:0] got);
    got = '0;
    for (int k = 1; k <= nrise; k++) begin
      @(posedge clk); #1 ssi_clk = 0;
      repeat (HALF) @(posedge clk);
      #1 ssi_clk = 1;
      repeat (HALF - 2) @(posedge clk);
      @(negedge clk);
      if (k <= W) got[W-k] = ssi_dout;
    end
  endtask

  task automatic wait_end();
    repeat (TOUT + 20) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dout", ssi_dout, 1); chk("R1 busy", busy, 0);
    #1 rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 ready", ld_ready, 1); chk("R1 dout", ssi_dout, 1);

    // table walk: R4 word, R5 end pulse, R6 timeout, R9 no drift
    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      frame(W + 1, got);
      chk("R4/R9 word", got, VEC[i]);
      chk("R5 end high", ssi_dout, 1);
      repeat (TOUT / 2) @(posedge clk);
      @(negedge clk);
      chk("R5 held high busy", {ssi_dout, busy}, 2'b11);
      wait_end();
      chk("R6 busy drop", busy, 0);
      chk("R10 idle high", ssi_dout, 1);
    end

    // R7 aborted frame
    load(24'h123456);
    frame(10, got);
    chk("R7 partial", got[W-1:W-10], 10'b0001001000);
    wait_end();
    chk("R7 busy off", busy, 0);
    load(24'h3C5A96);
    frame(W + 1, got);
    chk("R7 restart msb", got, 24'h3C5A96);
    wait_end();

    // R8 host write during a frame; R2 latest word wins
    load(24'h0F0F0F);
    fork
      frame(W + 1, got);
      begin repeat (150) @(posedge clk); load(24'h777777); end
    join
    chk("R8 frame intact", got, 24'h0F0F0F);
    wait_end();
    load(24'h111111);
    load(24'h2468AC);
    frame(W + 1, got);
    chk("R2/R8 latest", got, 24'h2468AC);
    wait_end();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule